// File: doc/BRIEF.md
# Four-Channel DMA Controller Host Register File

This block is the processor-facing register bank of a four-channel DMA controller. A host reaches it through a 4-bit register offset, an 8-bit data bus, a chip select and separate read and write strobes. For each channel it keeps 16-bit start and working copies of a memory address and a transfer count, plus a 6-bit channel mode. Shared state covers a command byte, a status byte, a 4-bit channel mask, software request bits and one temporary data byte.

The working address, count, mode, command, mask and software requests go out as plain vectors to the transfer engine and arbiter, which are separate blocks. The engine writes back through a single-cycle update port. That port replaces one channel's working address and count, and can flag terminal count and mask the channel. A separate strobe loads the temporary byte. The 16-bit registers pass through the 8-bit bus one byte at a time. A shared byte-pointer flag selects which half each access touches.

Top module: `dmac_regfile`

## Requirements
- R1: Offsets 0 to 7 are channel registers. Offset bits 2:1 give the channel, and offset bit 0 selects address (0) or count (1). A write stores the byte into both the start copy and the working copy. A read returns the working copy.
- R2: A shared byte pointer selects the low byte when 0 and the high byte when 1. It flips after every read or write access (cs with rd_en or wr_en) to offsets 0 to 7.
- R3: A write to offset 12 forces the byte pointer to 0, whatever the data.
- R4: A read of offset 8 returns the status byte and then clears bits 3:0, which hold terminal count for channels 0 to 3. Bits 7:4 hold dreq_i as sampled on the previous clock, and a status read leaves them unchanged.
- R5: A write to offset 8 loads the command byte, which appears on command_o after the clock edge.
- R6: A write to offset 9 sets (data bit 2 = 1) or clears (data bit 2 = 0) the software request of the channel in data bits 1:0. A terminal-count update for a channel clears that channel's software request.
- R7: Offset 10 sets or clears one mask bit (channel in data bits 1:0, set when data bit 2 = 1). Offset 14 clears all four mask bits. A write to offset 15 loads the mask from data bits 3:0. A read of offset 15 returns the mask in bits 3:0, with bits 7:4 zero.
- R8: A write to offset 11 stores data bits 7:2 as the mode of the channel in data bits 1:0. It also clears that channel's terminal-count status bit.
- R9: A write to offset 13 is a master clear. It zeroes command, status, software requests, the temporary byte and the byte pointer, and sets all four mask bits. Channel registers keep their values.
- R10: A read of offset 13 returns the temporary byte. A pulse on temp_we_i loads temp_i into the temporary byte.
- R11: An update pulse replaces the chosen channel's working address and count and leaves the start copies unchanged. It ORs in that channel's terminal-count status bit (upd_tc_i) and mask bit (upd_mask_i). Over a host write to the same working copy, and over any clear of the same bit in that cycle, the update wins.
- R12: Reads of the write-only offsets 9, 10, 11, 12 and 14 return zero.
- R13: After reset the mask is 4'hF, command, status, software requests, temporary byte and byte pointer are zero, and all channel registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd_en | input | 1 | Read strobe; read side effects apply at the clock edge |
| wr_en | input | 1 | Write strobe |
| reg_off | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the offset |
| dreq_i | input | 4 | Channel request levels, sampled into status bits 7:4 |
| upd_valid_i | input | 1 | Engine update strobe |
| upd_chan_i | input | 2 | Channel being updated |
| upd_addr_i | input | 16 | New working address |
| upd_cnt_i | input | 16 | New working count |
| upd_tc_i | input | 1 | Set terminal-count status for the channel |
| upd_mask_i | input | 1 | Set the channel's mask bit |
| temp_we_i | input | 1 | Temporary byte load strobe |
| temp_i | input | 8 | Temporary byte value |
| cur_addr_o | output | 64 | Working addresses, channel n at bits 16n+15:16n |
| cur_cnt_o | output | 64 | Working counts, same packing |
| base_addr_o | output | 64 | Start addresses, same packing |
| base_cnt_o | output | 64 | Start counts, same packing |
| mode_o | output | 24 | Channel modes, channel n at bits 6n+5:6n |
| command_o | output | 8 | Command byte |
| mask_o | output | 4 | Channel mask bits |
| sw_req_o | output | 4 | Software request bits |

## Verification
A byte pointer in the wrong state has no effect until the next 16-bit access, which then lands on the wrong half. The first read-back of a two-byte value shows it, with the two bytes swapped. A wrong terminal-count bit shows on the next status read, and the clear-on-read rule means only the first read carries it. Mask, command, mode and request faults show on their output vectors one clock after the write that caused them. The bench therefore checks paired byte read-backs, back-to-back status reads and the output vectors right after each edge.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

    localparam int NCH    = 4;
    localparam int CHW    = $clog2(NCH);
    localparam int DW     = 8;
    localparam int AW     = 2 * DW;
    localparam int CW     = 2 * DW;
    localparam int MODEW  = DW - CHW;
    localparam int OFFW   = 4;

    typedef enum logic [OFFW-1:0] {
        OFF_STAT_CMD = 4'd8,
        OFF_SWREQ    = 4'd9,
        OFF_SMASK    = 4'd10,
        OFF_MODE     = 4'd11,
        OFF_PTRCLR   = 4'd12,
        OFF_TMP_MCLR = 4'd13,
        OFF_MASKCLR  = 4'd14,
        OFF_MASKALL  = 4'd15
    } ctl_off_e;

    typedef struct packed {
        logic           valid;
        logic [CHW-1:0] chan;
        logic           tc;
        logic           mask;
    } upd_flags_t;

    // Replace one byte of a two-byte register.
    function automatic logic [2*DW-1:0] put_byte(input logic [2*DW-1:0] old,
                                                 input logic hi,
                                                 input logic [DW-1:0] b);
        logic [2*DW-1:0] r;
        r = old;
        if (hi) r[2*DW-1:DW] = b;
        else    r[DW-1:0]    = b;
        return r;
    endfunction

    function automatic logic [DW-1:0] get_byte(input logic [2*DW-1:0] v,
                                               input logic hi);
        return hi ? v[2*DW-1:DW] : v[DW-1:0];
    endfunction

endpackage

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
    import dmac_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_we,
    input  logic             cnt_we,
    input  logic             hi_sel,
    input  logic [DW-1:0]    wdata,
    input  logic             mode_we,
    input  logic [MODEW-1:0] mode_d,
    input  logic             upd_we,
    input  logic [AW-1:0]    upd_addr,
    input  logic [CW-1:0]    upd_cnt,
    output logic [AW-1:0]    base_addr,
    output logic [AW-1:0]    cur_addr,
    output logic [CW-1:0]    base_cnt,
    output logic [CW-1:0]    cur_cnt,
    output logic [MODEW-1:0] mode
);

    logic [AW-1:0]    base_addr_n, cur_addr_n;
    logic [CW-1:0]    base_cnt_n, cur_cnt_n;
    logic [MODEW-1:0] mode_n;

    always_comb begin
        base_addr_n = base_addr;
        cur_addr_n  = cur_addr;
        base_cnt_n  = base_cnt;
        cur_cnt_n   = cur_cnt;
        mode_n      = mode;
        if (addr_we) begin
            base_addr_n = put_byte(base_addr, hi_sel, wdata);
            cur_addr_n  = put_byte(cur_addr, hi_sel, wdata);
        end
        if (cnt_we) begin
            base_cnt_n = put_byte(base_cnt, hi_sel, wdata);
            cur_cnt_n  = put_byte(cur_cnt, hi_sel, wdata);
        end
        // engine update takes precedence over the host on working copies
        if (upd_we) begin
            cur_addr_n = upd_addr;
            cur_cnt_n  = upd_cnt;
        end
        if (mode_we) mode_n = mode_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            cur_addr  <= '0;
            base_cnt  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
        end else begin
            base_addr <= base_addr_n;
            cur_addr  <= cur_addr_n;
            base_cnt  <= base_cnt_n;
            cur_cnt   <= cur_cnt_n;
            mode      <= mode_n;
        end
    end

endmodule

// File: rtl/dmac_ctrl_bank.sv
module dmac_ctrl_bank
    import dmac_regs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_rd,
    input  logic            acc_wr,
    input  logic [OFFW-1:0] reg_off,
    input  logic [DW-1:0]   wdata,
    input  logic [NCH-1:0]  dreq,
    input  upd_flags_t      upd,
    input  logic            temp_we,
    input  logic [DW-1:0]   temp_d,
    output logic [DW-1:0]   command,
    output logic [DW-1:0]   status,
    output logic [NCH-1:0]  mask,
    output logic [NCH-1:0]  swreq,
    output logic [DW-1:0]   temp,
    output logic            ptr
);

    logic [DW-1:0]  command_n, temp_n;
    logic [NCH-1:0] tc_n, req_n, mask_n, swreq_n;
    logic           ptr_n;
    logic           chan_acc, mclr;
    logic [CHW-1:0] wchan;

    assign chan_acc = (acc_rd | acc_wr) & ~reg_off[OFFW-1];
    assign mclr     = acc_wr & (reg_off == OFF_TMP_MCLR);
    assign wchan    = wdata[CHW-1:0];

    always_comb begin
        command_n = command;
        temp_n    = temp;
        tc_n      = status[NCH-1:0];
        req_n     = dreq;
        mask_n    = mask;
        swreq_n   = swreq;
        ptr_n     = ptr;
        if (mclr) begin
            command_n = '0;
            temp_n    = '0;
            tc_n      = '0;
            req_n     = '0;
            swreq_n   = '0;
            mask_n    = '1;
            ptr_n     = 1'b0;
        end else begin
            if (chan_acc) ptr_n = ~ptr;
            if (acc_rd && reg_off == OFF_STAT_CMD) tc_n = '0;
            if (acc_wr) begin
                case (reg_off)
                    OFF_STAT_CMD: command_n = wdata;
                    OFF_SWREQ:    swreq_n[wchan] = wdata[CHW];
                    OFF_SMASK:    mask_n[wchan]  = wdata[CHW];
                    OFF_MODE:     tc_n[wchan]    = 1'b0;
                    OFF_PTRCLR:   ptr_n = 1'b0;
                    OFF_MASKCLR:  mask_n = '0;
                    OFF_MASKALL:  mask_n = wdata[NCH-1:0];
                    default: ;
                endcase
            end
        end
        // engine flags are applied last so they win over any clear
        if (upd.valid) begin
            if (upd.tc) begin
                tc_n[upd.chan]    = 1'b1;
                swreq_n[upd.chan] = 1'b0;
            end
            if (upd.mask) mask_n[upd.chan] = 1'b1;
        end
        if (temp_we) temp_n = temp_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            command <= '0;
            status  <= '0;
            mask    <= '1;
            swreq   <= '0;
            temp    <= '0;
            ptr     <= 1'b0;
        end else begin
            command <= command_n;
            status  <= {req_n, tc_n};
            mask    <= mask_n;
            swreq   <= swreq_n;
            temp    <= temp_n;
            ptr     <= ptr_n;
        end
    end

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [3:0]        reg_off,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [3:0]        dreq_i,
    input  logic              upd_valid_i,
    input  logic [1:0]        upd_chan_i,
    input  logic [15:0]       upd_addr_i,
    input  logic [15:0]       upd_cnt_i,
    input  logic              upd_tc_i,
    input  logic              upd_mask_i,
    input  logic              temp_we_i,
    input  logic [7:0]        temp_i,
    output logic [63:0]       cur_addr_o,
    output logic [63:0]       cur_cnt_o,
    output logic [63:0]       base_addr_o,
    output logic [63:0]       base_cnt_o,
    output logic [23:0]       mode_o,
    output logic [7:0]        command_o,
    output logic [3:0]        mask_o,
    output logic [3:0]        sw_req_o
);

    logic            acc_rd, acc_wr;
    logic            ptr_q;
    logic [DW-1:0]   status_q, temp_q;
    upd_flags_t      upd;

    logic [AW-1:0]    cur_addr_a  [NCH];
    logic [AW-1:0]    base_addr_a [NCH];
    logic [CW-1:0]    cur_cnt_a   [NCH];
    logic [CW-1:0]    base_cnt_a  [NCH];
    logic [MODEW-1:0] mode_a      [NCH];

    assign acc_rd = cs & rd_en;
    assign acc_wr = cs & wr_en;
    assign upd    = '{valid: upd_valid_i, chan: upd_chan_i,
                      tc: upd_tc_i, mask: upd_mask_i};

    dmac_ctrl_bank ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .acc_rd  (acc_rd),
        .acc_wr  (acc_wr),
        .reg_off (reg_off),
        .wdata   (wdata),
        .dreq    (dreq_i),
        .upd     (upd),
        .temp_we (temp_we_i),
        .temp_d  (temp_i),
        .command (command_o),
        .status  (status_q),
        .mask    (mask_o),
        .swreq   (sw_req_o),
        .temp    (temp_q),
        .ptr     (ptr_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic sel, addr_we, cnt_we, mode_we, upd_we;
        assign sel     = ~reg_off[OFFW-1] && (reg_off[CHW:1] == CHW'(g));
        assign addr_we = acc_wr & sel & ~reg_off[0];
        assign cnt_we  = acc_wr & sel &  reg_off[0];
        assign mode_we = acc_wr && (reg_off == OFF_MODE)
                         && (wdata[CHW-1:0] == CHW'(g));
        assign upd_we  = upd_valid_i && (upd_chan_i == CHW'(g));

        dmac_chan_bank bank_i (
            .clk       (clk),
            .rst       (rst),
            .addr_we   (addr_we),
            .cnt_we    (cnt_we),
            .hi_sel    (ptr_q),
            .wdata     (wdata),
            .mode_we   (mode_we),
            .mode_d    (wdata[DW-1:CHW]),
            .upd_we    (upd_we),
            .upd_addr  (upd_addr_i),
            .upd_cnt   (upd_cnt_i),
            .base_addr (base_addr_a[g]),
            .cur_addr  (cur_addr_a[g]),
            .base_cnt  (base_cnt_a[g]),
            .cur_cnt   (cur_cnt_a[g]),
            .mode      (mode_a[g])
        );

        assign cur_addr_o [g*AW +: AW]       = cur_addr_a[g];
        assign base_addr_o[g*AW +: AW]       = base_addr_a[g];
        assign cur_cnt_o  [g*CW +: CW]       = cur_cnt_a[g];
        assign base_cnt_o [g*CW +: CW]       = base_cnt_a[g];
        assign mode_o     [g*MODEW +: MODEW] = mode_a[g];
    end

    always_comb begin
        logic [CHW-1:0] rch;
        rch   = reg_off[CHW:1];
        rdata = '0;
        if (!reg_off[OFFW-1]) begin
            rdata = reg_off[0] ? get_byte(cur_cnt_a[rch], ptr_q)
                               : get_byte(cur_addr_a[rch], ptr_q);
        end else begin
            case (reg_off)
                OFF_STAT_CMD: rdata = status_q;
                OFF_TMP_MCLR: rdata = temp_q;
                OFF_MASKALL:  rdata = {{(DW-NCH){1'b0}}, mask_o};
                default:      rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs,
    input logic       rd_en,
    input logic       wr_en,
    input logic [3:0] reg_off,
    input logic [7:0] wdata,
    input logic       ptr_q,
    input logic [7:0] status_q,
    input logic [7:0] command_o,
    input logic [3:0] mask_o,
    input logic       upd_valid_i,
    input logic [1:0] upd_chan_i,
    input logic       upd_tc_i
);

    logic chan_acc, mclr;
    assign chan_acc = cs && (rd_en || wr_en) && !reg_off[3];
    assign mclr     = cs && wr_en && reg_off == 4'd13;

    assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        chan_acc |=> ptr_q != $past(ptr_q));

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cs && wr_en && reg_off == 4'd12) |=> !ptr_q);

    assert_stat_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (cs && rd_en && reg_off == 4'd8 && !(upd_valid_i && upd_tc_i))
        |=> status_q[3:0] == 4'd0);

    assert_cmd_load_R5: assert property (@(posedge clk) disable iff (rst)
        (cs && wr_en && reg_off == 4'd8) |=> command_o == $past(wdata));

    assert_mclr_R9: assert property (@(posedge clk) disable iff (rst)
        mclr |=> (mask_o == 4'hF && command_o == 8'h00 && !ptr_q));

    assert_upd_tc_R11: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_i && upd_tc_i) |=> status_q[$past(upd_chan_i)]);

endmodule

bind dmac_regfile dmac_regfile_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cs          (cs),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .reg_off     (reg_off),
    .wdata       (wdata),
    .ptr_q       (ptr_q),
    .status_q    (status_q),
    .command_o   (command_o),
    .mask_o      (mask_o),
    .upd_valid_i (upd_valid_i),
    .upd_chan_i  (upd_chan_i),
    .upd_tc_i    (upd_tc_i)
);

// File: tb/dmac_regfile_tb.sv
`timescale 1ns/1ps
module dmac_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs, rd_en, wr_en;
    logic [3:0]  reg_off;
    logic [7:0]  wdata, rdata;
    logic [3:0]  dreq_i;
    logic        upd_valid_i, upd_tc_i, upd_mask_i;
    logic [1:0]  upd_chan_i;
    logic [15:0] upd_addr_i, upd_cnt_i;
    logic        temp_we_i;
    logic [7:0]  temp_i;
    logic [63:0] cur_addr_o, cur_cnt_o, base_addr_o, base_cnt_o;
    logic [23:0] mode_o;
    logic [7:0]  command_o;
    logic [3:0]  mask_o, sw_req_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dmac_regfile dut_i (.*);

    // {write, offset, data, expected read}
    localparam int NV = 27;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 4'd0,  8'h34, 8'h00},
        {1'b1, 4'd0,  8'h12, 8'h00},
        {1'b0, 4'd0,  8'h00, 8'h34},
        {1'b0, 4'd0,  8'h00, 8'h12},
        {1'b1, 4'd3,  8'hCD, 8'h00},
        {1'b1, 4'd3,  8'hAB, 8'h00},
        {1'b0, 4'd3,  8'h00, 8'hCD},
        {1'b0, 4'd3,  8'h00, 8'hAB},
        {1'b1, 4'd6,  8'h55, 8'h00},
        {1'b1, 4'd12, 8'hFF, 8'h00},
        {1'b1, 4'd6,  8'h77, 8'h00},
        {1'b1, 4'd6,  8'h99, 8'h00},
        {1'b0, 4'd6,  8'h00, 8'h77},
        {1'b1, 4'd12, 8'h00, 8'h00},
        {1'b0, 4'd6,  8'h00, 8'h77},
        {1'b0, 4'd6,  8'h00, 8'h99},
        {1'b1, 4'd15, 8'hF5, 8'h00},
        {1'b0, 4'd15, 8'h00, 8'h05},
        {1'b1, 4'd10, 8'h05, 8'h00},
        {1'b0, 4'd15, 8'h00, 8'h07},
        {1'b1, 4'd10, 8'h00, 8'h00},
        {1'b0, 4'd15, 8'h00, 8'h06},
        {1'b1, 4'd14, 8'h00, 8'h00},
        {1'b0, 4'd15, 8'h00, 8'h00},
        {1'b0, 4'd9,  8'h00, 8'h00},
        {1'b0, 4'd11, 8'h00, 8'h00},
        {1'b1, 4'd8,  8'hA5, 8'h00}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] off);
        if (off < 4'd8)        return "R2";
        if (off == 4'd15)      return "R7";
        if (off == 4'd8)       return "R4";
        return "R12";
    endfunction

    // One host access; reads are compared before the edge that applies side effects.
    task automatic op(input bit wr, input logic [3:0] off, input logic [7:0] d,
                      input logic [7:0] exp, input string req);
        @(negedge clk);
        cs = 1'b1; rd_en = !wr; wr_en = wr; reg_off = off; wdata = d;
        #1;
        if (!wr) chk(req, {56'd0, rdata}, {56'd0, exp});
        @(posedge clk); #1;
        cs = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic upd(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] c,
                       input bit tc, input bit mk);
        @(negedge clk);
        upd_valid_i = 1'b1; upd_chan_i = ch; upd_addr_i = a; upd_cnt_i = c;
        upd_tc_i = tc; upd_mask_i = mk;
        @(posedge clk); #1;
        upd_valid_i = 1'b0; upd_tc_i = 1'b0; upd_mask_i = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cs = 0; rd_en = 0; wr_en = 0; reg_off = 0; wdata = 0;
        dreq_i = 0; upd_valid_i = 0; upd_chan_i = 0; upd_addr_i = 0; upd_cnt_i = 0;
        upd_tc_i = 0; upd_mask_i = 0; temp_we_i = 0; temp_i = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R13 reset state
        chk("R13 mask", 64'(mask_o), 64'hF);
        chk("R13 command", 64'(command_o), 64'h0);
        chk("R13 swreq", 64'(sw_req_o), 64'h0);
        chk("R13 addr", cur_addr_o | base_cnt_o, 64'h0);
        op(0, 4'd8, 8'h00, 8'h00, "R13");

        for (int i = 0; i < NV; i++)
            op(VEC[i][20], VEC[i][19:16], VEC[i][15:8], VEC[i][7:0], tag_of(VEC[i][19:16]));

        chk("R5 command", 64'(command_o), 64'hA5);
        chk("R1 base addr ch0", 64'(base_addr_o[15:0]), 64'h1234);
        chk("R1 base addr ch3", 64'(base_addr_o[63:48]), 64'h9977);
        chk("R1 cur count ch1", 64'(cur_cnt_o[31:16]), 64'hABCD);
        chk("R1 base count ch1", 64'(base_cnt_o[31:16]), 64'hABCD);

        // R8 mode write: channel 2, mode 0x2D
        op(1, 4'd11, 8'hB6, 8'h00, "R8");
        chk("R8 mode ch2", 64'(mode_o[17:12]), 64'h2D);

        // R11 update port
        upd(2'd0, 16'h1111, 16'h0005, 1'b1, 1'b1);
        chk("R11 cur addr", 64'(cur_addr_o[15:0]), 64'h1111);
        chk("R11 cur count", 64'(cur_cnt_o[15:0]), 64'h0005);
        chk("R11 base kept", 64'(base_addr_o[15:0]), 64'h1234);
        chk("R11 mask or", 64'(mask_o), 64'h1);
        op(0, 4'd8, 8'h00, 8'h01, "R4 tc set");
        op(0, 4'd8, 8'h00, 8'h00, "R4 tc cleared");

        // R4 request nibble survives reads
        dreq_i = 4'b1010;
        @(posedge clk); #1;
        op(0, 4'd8, 8'h00, 8'hA0, "R4 req");
        op(0, 4'd8, 8'h00, 8'hA0, "R4 req kept");

        // R6 software requests
        op(1, 4'd9, 8'h06, 8'h00, "R6");
        chk("R6 set", 64'(sw_req_o), 64'h4);
        op(1, 4'd9, 8'h02, 8'h00, "R6");
        chk("R6 clear", 64'(sw_req_o), 64'h0);
        op(1, 4'd9, 8'h06, 8'h00, "R6");
        upd(2'd2, 16'h0, 16'h0, 1'b1, 1'b0);
        chk("R6 tc clears request", 64'(sw_req_o), 64'h0);
        op(1, 4'd11, 8'hB6, 8'h00, "R8");
        op(0, 4'd8, 8'h00, 8'hA0, "R8 tc cleared by mode");

        // R11 update wins over host write to the same working copy (ptr=0)
        @(negedge clk);
        cs = 1; wr_en = 1; reg_off = 4'd0; wdata = 8'hEE;
        upd_valid_i = 1; upd_chan_i = 0; upd_addr_i = 16'h2222; upd_cnt_i = 16'h0005;
        @(posedge clk); #1;
        cs = 0; wr_en = 0; upd_valid_i = 0;
        chk("R11 priority cur", 64'(cur_addr_o[15:0]), 64'h2222);
        chk("R1 base low byte", 64'(base_addr_o[15:0]), 64'h12EE);

        // R10 temporary byte
        @(negedge clk); temp_we_i = 1; temp_i = 8'h3C;
        @(posedge clk); #1 temp_we_i = 0;
        op(0, 4'd13, 8'h00, 8'h3C, "R10");

        // R9 master clear (pointer currently 1)
        dreq_i = 4'b0000;
        op(1, 4'd9, 8'h05, 8'h00, "R6");
        op(1, 4'd13, 8'h00, 8'h00, "R9");
        chk("R9 mask", 64'(mask_o), 64'hF);
        chk("R9 command", 64'(command_o), 64'h0);
        chk("R9 swreq", 64'(sw_req_o), 64'h0);
        chk("R9 channel kept", 64'(cur_cnt_o[31:16]), 64'hABCD);
        op(0, 4'd13, 8'h00, 8'h00, "R9 temp");
        op(0, 4'd3, 8'h00, 8'hCD, "R9 pointer low");
        op(0, 4'd8, 8'h00, 8'h00, "R9 status");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule